// File: doc/BRIEF.md
# TDM serial audio receiver

This block turns a continuous time-division-multiplexed serial stream into parallel slot words. One data bit and one frame-sync bit are sampled on every rising edge of the serial clock. A leading edge of the frame sync marks the start of a frame. The first data bit of slot 0 then arrives a programmable 0, 1 or 2 clocks later. From that point on, slot boundaries come only from counting a programmed number of bits per slot. Slots follow one another with no gap bits, and the frame wraps back to slot 0 after the last programmed slot.

Each completed slot is presented as a right-aligned, MSB-first word together with its slot index and a single-cycle valid strobe. The receiver stays silent until it has seen its first frame sync after reset. A frame sync edge that does not line up with the frame start the counters expect sets a sticky error flag, and the receiver then realigns to the new frame.

Top module: `tdm_slot_rx`

## Requirements
- R1: One data bit is sampled per rising clock edge. A slot word holds its cfg_bits bits MSB first (the first bit received ends up at bit cfg_bits-1), right-aligned in word_o, with every bit from cfg_bits upward zero.
- R2: Slots are contiguous with no gap bits. Bit 0 of slot n+1 is the bit sampled right after the last bit of slot n. The slot index counts 0 to cfg_slots-1 and then returns to 0 with no gap.
- R3: The first bit of slot 0 is sampled cfg_delay clocks (0, 1 or 2) after the clock in which frame sync is first sampled high after being sampled low. With a delay of 0, this is the same clock.
- R4: Only the low-to-high transition of frame sync matters. A sync one bit wide and a sync one slot wide give identical words.
- R5: valid_o is high for exactly one clock, in the clock after the last bit of a slot is sampled. In that clock word_o and slot_o carry that slot's data and index.
- R6: From reset until the first frame sync edge, valid_o stays low whatever the data input does.
- R7: If a frame sync edge places slot 0 anywhere other than the position the bit counters predict, sync_err_o rises one clock after that slot-0 bit is sampled and stays high until reset. The receiver restarts its framing at the new slot 0.
- R8: cfg_bits accepts any value from 8 to 32 and cfg_slots any value from 2 to 16; both hold the plain count.
- R9: While rst_n is low and right after it is released, valid_o, sync_err_o, word_o and slot_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cfg_bits | input | 6 | Bits per slot, 8 to 32 |
| cfg_slots | input | 5 | Slots per frame, 2 to 16 |
| cfg_delay | input | 2 | Clocks from frame sync edge to first bit of slot 0, 0 to 2 |
| sd_in | input | 1 | Serial data bit |
| fs_in | input | 1 | Frame sync |
| word_o | output | 32 | Received slot word, right-aligned |
| slot_o | output | 4 | Index of the slot in word_o |
| valid_o | output | 1 | One-clock strobe for word_o and slot_o |
| sync_err_o | output | 1 | Sticky misplaced frame sync flag |

## Verification
The assertions assume that cfg_bits, cfg_slots and cfg_delay hold legal values and do not change while the receiver is framing. Under that assumption, the slot index bound, the minimum spacing between valid strobes and the zero upper word bits all follow. The bench sets the configuration only while reset is held, and it uses only values inside the legal ranges. Within each configuration it drives frame syncs of one bit or one slot wide that go low again well before the next edge. Misplaced syncs are injected only as a slip shorter than one slot, so the stray bits never complete a word.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    // Position tag attached to every sampled serial bit
    typedef struct packed {
        logic vld;    // bit belongs to a framed slot
        logic first;  // bit is the MSB of its slot
        logic last;   // bit is the LSB of its slot
    } bit_tag_t;

endpackage

// File: rtl/tdm_fs_align.sv
module tdm_fs_align #(
    parameter int MAX_DLY = 2,
    localparam int DW = $clog2(MAX_DLY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fs_in,
    input  logic [DW-1:0] cfg_delay,
    output logic          sof_o
);

    typedef struct packed {
        logic               fs_prev;
        logic [MAX_DLY-1:0] pipe;
    } st_t;

    st_t st_d, st_q;
    logic             lead;
    logic [MAX_DLY:0] tap;

    assign lead   = fs_in & ~st_q.fs_prev;
    assign tap[0] = lead;

    generate
        for (genvar g = 1; g <= MAX_DLY; g++) begin : g_tap
            assign tap[g] = st_q.pipe[g-1];
        end
    endgenerate

    always_comb begin
        st_d         = st_q;
        st_d.fs_prev = fs_in;
        st_d.pipe[0] = lead;
        for (int i = 1; i < MAX_DLY; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        sof_o = 1'b0;
        if (int'(cfg_delay) <= MAX_DLY) begin
            sof_o = tap[cfg_delay];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    delay_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cfg_delay) <= MAX_DLY);

endmodule

// File: rtl/tdm_slot_track.sv
module tdm_slot_track
    import tdm_rx_pkg::*;
#(
    parameter int MAX_BITS  = 32,
    parameter int MAX_SLOTS = 16,
    localparam int BCW = $clog2(MAX_BITS + 1),
    localparam int SCW = $clog2(MAX_SLOTS + 1),
    localparam int BIW = $clog2(MAX_BITS),
    localparam int SIW = $clog2(MAX_SLOTS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [BCW-1:0] cfg_bits,
    input  logic [SCW-1:0] cfg_slots,
    input  logic           sof_i,
    output bit_tag_t       tag_o,
    output logic [SIW-1:0] slot_o,
    output logic           locked_o,
    output logic           err_o
);

    typedef struct packed {
        logic           locked;
        logic           err;
        logic [BIW-1:0] bit_idx;
        logic [SIW-1:0] slot_idx;
    } st_t;

    st_t st_d, st_q;
    logic [BIW-1:0] cur_bit;
    logic [SIW-1:0] cur_slot;
    logic           cur_vld;
    logic           cur_last;
    logic           off_frame_start;

    always_comb begin
        // position of the bit being sampled in this clock
        if (sof_i) begin
            cur_bit  = '0;
            cur_slot = '0;
            cur_vld  = 1'b1;
        end else begin
            cur_bit  = st_q.bit_idx;
            cur_slot = st_q.slot_idx;
            cur_vld  = st_q.locked;
        end
        cur_last = (BCW'(cur_bit) == cfg_bits - BCW'(1));
        off_frame_start = (st_q.bit_idx != '0) || (st_q.slot_idx != '0);

        st_d = st_q;
        if (sof_i) begin
            st_d.locked = 1'b1;
            if (st_q.locked && off_frame_start) begin
                st_d.err = 1'b1;
            end
        end
        if (cur_vld) begin
            if (cur_last) begin
                st_d.bit_idx = '0;
                if (SCW'(cur_slot) == cfg_slots - SCW'(1)) begin
                    st_d.slot_idx = '0;
                end else begin
                    st_d.slot_idx = cur_slot + SIW'(1);
                end
            end else begin
                st_d.bit_idx  = cur_bit + BIW'(1);
                st_d.slot_idx = cur_slot;
            end
        end

        tag_o.vld   = cur_vld;
        tag_o.first = cur_vld && (cur_bit == '0);
        tag_o.last  = cur_vld && cur_last;
        slot_o      = cur_slot;
        locked_o    = st_q.locked;
        err_o       = st_q.err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    slot_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |-> (SCW'(st_q.slot_idx) < cfg_slots));

    // R1
    bit_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |-> (BCW'(st_q.bit_idx) < cfg_bits));

endmodule

// File: rtl/tdm_word_shift.sv
module tdm_word_shift
    import tdm_rx_pkg::*;
#(
    parameter int MAX_BITS  = 32,
    parameter int MAX_SLOTS = 16,
    localparam int SIW = $clog2(MAX_SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sd_i,
    input  bit_tag_t            tag_i,
    input  logic [SIW-1:0]      slot_i,
    output logic [MAX_BITS-1:0] word_o,
    output logic [SIW-1:0]      slot_o,
    output logic                valid_o
);

    typedef struct packed {
        logic [MAX_BITS-1:0] acc;
        logic [MAX_BITS-1:0] word;
        logic [SIW-1:0]      slot;
        logic                valid;
    } st_t;

    st_t st_d, st_q;
    logic [MAX_BITS-1:0] base;
    logic [MAX_BITS-1:0] acc_next;

    always_comb begin
        base     = tag_i.first ? '0 : st_q.acc;
        acc_next = {base[MAX_BITS-2:0], sd_i};

        st_d       = st_q;
        st_d.valid = 1'b0;
        if (tag_i.vld) begin
            st_d.acc = acc_next;
            if (tag_i.last) begin
                st_d.word  = acc_next;
                st_d.slot  = slot_i;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o  = st_q.word;
    assign slot_o  = st_q.slot;
    assign valid_o = st_q.valid;

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_d.valid |=> $stable(word_o));

endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
    import tdm_rx_pkg::*;
#(
    parameter int MAX_BITS  = 32,
    parameter int MIN_BITS  = 8,
    parameter int MAX_SLOTS = 16,
    parameter int MIN_SLOTS = 2,
    parameter int MAX_DLY   = 2,
    localparam int BCW = $clog2(MAX_BITS + 1),
    localparam int SCW = $clog2(MAX_SLOTS + 1),
    localparam int SIW = $clog2(MAX_SLOTS),
    localparam int DW  = $clog2(MAX_DLY + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BCW-1:0]      cfg_bits,
    input  logic [SCW-1:0]      cfg_slots,
    input  logic [DW-1:0]       cfg_delay,
    input  logic                sd_in,
    input  logic                fs_in,
    output logic [MAX_BITS-1:0] word_o,
    output logic [SIW-1:0]      slot_o,
    output logic                valid_o,
    output logic                sync_err_o
);

    logic           sof;
    bit_tag_t       tag;
    logic [SIW-1:0] bit_slot;
    logic           locked;

    tdm_fs_align #(
        .MAX_DLY (MAX_DLY)
    ) i_fs_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_in     (fs_in),
        .cfg_delay (cfg_delay),
        .sof_o     (sof)
    );

    tdm_slot_track #(
        .MAX_BITS  (MAX_BITS),
        .MAX_SLOTS (MAX_SLOTS)
    ) i_slot_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_bits  (cfg_bits),
        .cfg_slots (cfg_slots),
        .sof_i     (sof),
        .tag_o     (tag),
        .slot_o    (bit_slot),
        .locked_o  (locked),
        .err_o     (sync_err_o)
    );

    tdm_word_shift #(
        .MAX_BITS  (MAX_BITS),
        .MAX_SLOTS (MAX_SLOTS)
    ) i_word_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sd_i    (sd_in),
        .tag_i   (tag),
        .slot_i  (bit_slot),
        .word_o  (word_o),
        .slot_o  (slot_o),
        .valid_o (valid_o)
    );

    // R8
    cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_bits) >= MIN_BITS) && (int'(cfg_bits) <= MAX_BITS) &&
        (int'(cfg_slots) >= MIN_SLOTS) && (int'(cfg_slots) <= MAX_SLOTS));

    // R6
    no_word_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> !valid_o);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err_o |=> sync_err_o);

    // R1
    word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((word_o >> cfg_bits) == '0));

endmodule

// File: tb/test_tdm_slot_rx.sv
module test_tdm_slot_rx;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_bits = 6'd8;
    logic [4:0]  cfg_slots = 5'd2;
    logic [1:0]  cfg_delay = 2'd0;
    logic        sd_in = 1'b0;
    logic        fs_in = 1'b0;
    logic [31:0] word_o;
    logic [3:0]  slot_o;
    logic        valid_o;
    logic        sync_err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tdm_slot_rx i_tdm_slot_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_bits   (cfg_bits),
        .cfg_slots  (cfg_slots),
        .cfg_delay  (cfg_delay),
        .sd_in      (sd_in),
        .fs_in      (fs_in),
        .word_o     (word_o),
        .slot_o     (slot_o),
        .valid_o    (valid_o),
        .sync_err_o (sync_err_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_val(input int f, input int s, input int b);
        logic [31:0] h;
        logic [31:0] mask;
        h    = 32'(f * 37 + s * 101 + b * 13 + 5) * 32'h9E3779B1;
        h    = h ^ (h >> 15);
        mask = (b == 32) ? 32'hFFFF_FFFF : ((32'd1 << b) - 32'd1);
        return h & mask;
    endfunction

    task automatic do_reset(input int b, input int s, input int d);
        @(negedge clk);
        rst_n     = 1'b0;
        fs_in     = 1'b0;
        sd_in     = 1'b1;
        cfg_bits  = 6'(b);
        cfg_slots = 5'(s);
        cfg_delay = 2'(d);
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk(valid_o == 1'b0 && sync_err_o == 1'b0 && word_o == '0 && slot_o == '0,
            "R9 reset outputs", {valid_o, sync_err_o, slot_o, word_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(valid_o == 1'b0 && sync_err_o == 1'b0, "R9 after release",
            {valid_o, sync_err_o}, 0);
    endtask

    // One stream: nf frames; frames from 1 onward start slip clocks late
    task automatic run_stream(input int b, input int s, input int d, input int wid,
                              input int nf, input int slip);
        int f_len;
        int total;
        int err_cycle;
        f_len     = b * s;
        total     = d + nf * f_len + slip;
        err_cycle = (slip > 0) ? d + f_len + slip : -1;
        do_reset(b, s, d);
        for (int c = 0; c < total; c++) begin
            logic fs_v;
            logic sd_v;
            logic data;
            int   p;
            int   pp;
            int   fr;
            int   sl;
            int   bi;
            logic [31:0] w;
            fs_v = 1'b0;
            for (int k = 0; k < nf; k++) begin
                int st;
                st = (k == 0) ? 0 : k * f_len + slip;
                if (c >= st && c < st + wid) fs_v = 1'b1;
            end
            p    = c - d;
            data = 1'b0;
            pp   = 0;
            if (p >= 0 && p < f_len) begin
                data = 1'b1;
                pp   = p;
            end else if (p >= f_len + slip) begin
                data = 1'b1;
                pp   = p - slip;
            end
            fr   = pp / f_len;
            sl   = (pp % f_len) / b;
            bi   = pp % b;
            w    = word_val(fr, sl, b);
            sd_v = data ? w[b - 1 - bi] : 1'b1;

            @(negedge clk);
            fs_in = fs_v;
            sd_in = sd_v;
            @(posedge clk);
            #1;
            if (data && bi == b - 1) begin
                // R5 strobe with word, R1 MSB first, R2 slot order, R3 delay, R4 width
                chk(valid_o == 1'b1, "R5 valid at slot end", valid_o, 1);
                chk(word_o == w, "R1 R3 R4 word", word_o, w);
                chk(slot_o == 4'(sl), "R2 slot index", slot_o, sl);
            end else if (p < 0) begin
                chk(valid_o == 1'b0, "R6 no word before sync", valid_o, 0);
            end else begin
                chk(valid_o == 1'b0, "R5 valid low mid-slot", valid_o, 0);
            end
            if (err_cycle >= 0 && c >= err_cycle) begin
                chk(sync_err_o == 1'b1, "R7 sync error set and held", sync_err_o, 1);
            end else begin
                chk(sync_err_o == 1'b0, "R7 sync error clear", sync_err_o, 0);
            end
        end
    endtask

    // Data toggles but no frame sync ever rises
    task automatic run_no_sync(input int b, input int s);
        do_reset(b, s, 0);
        for (int c = 0; c < 3 * b * s; c++) begin
            @(negedge clk);
            fs_in = 1'b0;
            sd_in = c[0] ^ c[2];
            @(posedge clk);
            #1;
            chk(valid_o == 1'b0, "R6 silent without sync", valid_o, 0);
        end
    endtask

    initial begin
        int bits_set[3];
        int slots_set[3];
        bits_set  = '{8, 13, 32};
        slots_set = '{2, 5, 16};

        run_no_sync(8, 2);

        // R8 sweep over size extremes, all delays, both sync widths
        foreach (bits_set[i]) begin
            foreach (slots_set[j]) begin
                for (int d = 0; d <= 2; d++) begin
                    run_stream(bits_set[i], slots_set[j], d, 1, 3, 0);
                    run_stream(bits_set[i], slots_set[j], d, bits_set[i], 3, 0);
                end
            end
        end

        // R7 misplaced sync, realignment
        run_stream(8, 3, 1, 1, 3, 3);
        run_stream(8, 2, 0, 8, 3, 5);
        run_stream(16, 4, 2, 1, 3, 7);
        run_stream(32, 2, 2, 32, 3, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule